// File: doc/BRIEF.md
# Decade Counter with Seven-Segment Decoder

This block keeps a single decimal digit in a synchronous modulo-10 counter and turns it into seven active-high segment drive lines. The counter advances on rising clock edges while enabled. A synchronous active-low load forces it back to zero, and an active-low asynchronous clear zeroes it at once. The four-bit count itself stays inside the block.

The segment lines come from combinational logic fed by the count and three active-low display controls. These controls have a fixed priority. Blanking turns every segment off. Lamp test comes next and turns every segment on. Zero suppression is last and darkens the digit only when the count is zero. A typical use is one digit of a display. The zero-suppression input lets a leading zero go dark while other digits still show.

Top module: `decade_seg_counter`

## Requirements
- R1: With `cnt_en` high and `load_n` high, each rising clock edge adds one to the count, and the count goes from 9 to 0.
- R2: With `load_n` low, the next rising edge sets the count to 0, whatever `cnt_en` is.
- R3: With `cnt_en` low and `load_n` high, the count keeps its value across clock edges.
- R4: Driving `rst_n` low sets the count to 0 at once, with no clock edge needed, so the outputs show digit 0.
- R5: With `blank_n` low, `seg` is 7'h00, whatever the count, `lamp_n` and `zblank_n` are.
- R6: With `blank_n` high and `lamp_n` low, `seg` is 7'h7F.
- R7: With `blank_n` and `lamp_n` high and `zblank_n` low, `seg` is 7'h00 when the count is 0. For any other count, the normal digit pattern is shown.
- R8: With all three controls high, `seg` shows the count. `seg[0]` drives segment a and `seg[6]` drives segment g. The patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F, 67 in hex. Digit 6 leaves a dark and digit 9 leaves d dark. Segment g is off only for 0, 1 and 7.
- R9: `seg` follows changes on `blank_n`, `lamp_n` and `zblank_n` without waiting for a clock edge.
- R10: After `rst_n` goes high, the count stays 0 through the next two rising edges and can first change on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous clear; release is synchronized |
| cnt_en | input | 1 | Count enable, active high |
| load_n | input | 1 | Active-low synchronous load of zero |
| blank_n | input | 1 | Active-low blanking, highest priority |
| lamp_n | input | 1 | Active-low lamp test |
| zblank_n | input | 1 | Active-low zero suppression |
| seg | output | 7 | Segment drives, bit 0 = a through bit 6 = g, active high |

## Verification
The hardest case to reach is a clear that arrives between clock edges while the count is nonzero. The outputs have to change to digit 0 before any edge occurs. After that, the release has to hold the counter still for exactly two edges. The stimulus first drives the count away from zero and then drops `rst_n` shortly after a falling edge. It samples `seg` before the next rising edge, and then counts edges after release with the enable held high. Random stimulus also pulses the clear now and then, while a bench model tracks the release delay.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int SEG_W = 7;

  function automatic logic [SEG_W-1:0] digit_to_seg(input int unsigned d);
    logic [SEG_W-1:0] s;
    case (d)
      0:       s = 7'h3F;
      1:       s = 7'h06;
      2:       s = 7'h5B;
      3:       s = 7'h4F;
      4:       s = 7'h66;
      5:       s = 7'h6D;
      6:       s = 7'h7C;
      7:       s = 7'h07;
      8:       s = 7'h7F;
      9:       s = 7'h67;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load_n,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] count_d;

  always_comb begin
    if (!load_n)          count_d = '0;
    else if (en)          count_d = (count >= LAST) ? '0 : count + W'(1);
    else                  count_d = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/dsc_seg_decode.sv
module dsc_seg_decode
  import dsc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     digit,
  input  logic             blank_n,
  input  logic             lamp_n,
  input  logic             zblank_n,
  output logic [SEG_W-1:0] seg
);
  always_comb begin
    if (!blank_n)                        seg = '0;
    else if (!lamp_n)                    seg = '1;
    else if (!zblank_n && digit == '0)   seg = '0;
    else                                 seg = digit_to_seg(int'(digit));
  end
endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter #(
  parameter int W           = 4,
  parameter int MOD         = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       load_n,
  input  logic       blank_n,
  input  logic       lamp_n,
  input  logic       zblank_n,
  output logic [6:0] seg
);
  logic         core_rst_n;
  logic [W-1:0] count;

  dsc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (core_rst_n)
  );

  dsc_counter #(.W(W), .MOD(MOD)) u_cnt (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .en     (cnt_en),
    .load_n (load_n),
    .count  (count)
  );

  dsc_seg_decode #(.W(W)) u_dec (
    .digit    (count),
    .blank_n  (blank_n),
    .lamp_n   (lamp_n),
    .zblank_n (zblank_n),
    .seg      (seg)
  );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input logic         clk,
  input logic         core_rst_n,
  input logic         cnt_en,
  input logic         load_n,
  input logic         blank_n,
  input logic         lamp_n,
  input logic         zblank_n,
  input logic [W-1:0] count,
  input logic [6:0]   seg
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  a_r1_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    (load_n && cnt_en && count != LAST) |=> count == $past(count) + W'(1));

  a_r1_wrap: assert property (@(posedge clk) disable iff (!core_rst_n)
    (load_n && cnt_en && count == LAST) |=> count == '0);

  a_r2_load: assert property (@(posedge clk) disable iff (!core_rst_n)
    !load_n |=> count == '0);

  a_r3_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    (load_n && !cnt_en) |=> $stable(count));

  a_r5_blank: assert property (@(posedge clk) disable iff (!core_rst_n)
    !blank_n |-> seg == 7'h00);

  a_r6_lamp: assert property (@(posedge clk) disable iff (!core_rst_n)
    (blank_n && !lamp_n) |-> seg == 7'h7F);

  a_r7_zero_dark: assert property (@(posedge clk) disable iff (!core_rst_n)
    (blank_n && lamp_n && !zblank_n && count == '0) |-> seg == 7'h00);

  a_r8_range: assert property (@(posedge clk) disable iff (!core_rst_n)
    count <= LAST);
endmodule

bind decade_seg_counter dsc_checker #(.W(W), .MOD(MOD)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .cnt_en     (cnt_en),
  .load_n     (load_n),
  .blank_n    (blank_n),
  .lamp_n     (lamp_n),
  .zblank_n   (zblank_n),
  .count      (count),
  .seg        (seg)
);

// File: tb/decade_seg_counter_tb.sv
module decade_seg_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n, cnt_en, load_n, blank_n, lamp_n, zblank_n;
  logic [6:0] seg;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  int m_cnt  = 0;
  int m_wait = 2;

  decade_seg_counter u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load_n(load_n),
    .blank_n(blank_n), .lamp_n(lamp_n), .zblank_n(zblank_n), .seg(seg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] ref_digit(input int d);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7C, 7'h07, 7'h7F, 7'h67};
    return t[d];
  endfunction

  function automatic logic [6:0] ref_seg(input int d, input logic b, input logic l, input logic z);
    if (!b)                return 7'h00;
    if (!l)                return 7'h7F;
    if (!z && d == 0)      return 7'h00;
    return ref_digit(d);
  endfunction

  // bench model of the count, including the synchronized release (R10)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  = 0;
      m_wait = 2;
    end else if (m_wait > 0) begin
      m_wait = m_wait - 1;
    end else if (!load_n) begin
      m_cnt = 0;
    end else if (cnt_en) begin
      m_cnt = (m_cnt == 9) ? 0 : m_cnt + 1;
    end
  end

  task automatic check(input string tag);
    logic [6:0] exp_s;
    string t;
    exp_s = ref_seg(m_cnt, blank_n, lamp_n, zblank_n);
    if (tag != "") t = tag;
    else if (!blank_n) t = "R5";
    else if (!lamp_n) t = "R6";
    else if (!zblank_n && m_cnt == 0) t = "R7";
    else t = "R8";
    checks++;
    if (seg !== exp_s) begin
      errors++;
      $display("FAIL %s: seg=%h expected=%h (model count %0d)", t, seg, exp_s, m_cnt);
    end
  endtask

  task automatic tick(input logic e, input logic ld, input logic b,
                      input logic l, input logic z, input string tag);
    @(negedge clk);
    cnt_en = e; load_n = ld; blank_n = b; lamp_n = l; zblank_n = z;
    #1 check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    rst_n = 1'b0; cnt_en = 1'b1; load_n = 1'b1;
    blank_n = 1'b1; lamp_n = 1'b1; zblank_n = 1'b1;
    #3 check("R4");
    repeat (3) tick(1, 1, 1, 1, 1, "R4");

    // R10: release then two held edges, counting on the third
    @(negedge clk); rst_n = 1'b1;
    tick(1, 1, 1, 1, 1, "R10");
    tick(1, 1, 1, 1, 1, "R10");
    tick(1, 1, 1, 1, 1, "R10");
    tick(1, 1, 1, 1, 1, "R10");

    // R1/R8: walk all digits across the wrap
    repeat (22) tick(1, 1, 1, 1, 1, "");
    // R3: hold
    repeat (4) tick(0, 1, 1, 1, 1, "R3");
    // R2: load with enable high and low
    tick(1, 0, 1, 1, 1, "R2");
    tick(1, 1, 1, 1, 1, "R2");
    repeat (3) tick(1, 1, 1, 1, 1, "");
    tick(0, 0, 1, 1, 1, "R2");
    tick(0, 1, 1, 1, 1, "R2");

    // priority table at count 0 and at count 5
    for (int i = 0; i < 8; i++) tick(0, 1, i[2], i[1], i[0], "");
    repeat (5) tick(1, 1, 1, 1, 1, "");
    for (int i = 0; i < 8; i++) tick(0, 1, i[2], i[1], i[0], "");

    // R9: control changes seen without a clock edge
    @(negedge clk);
    cnt_en = 1'b0;
    #1 blank_n = 1'b0; #1 check("R9");
    #1 blank_n = 1'b1; lamp_n = 1'b0; #1 check("R9");
    #1 lamp_n = 1'b1; #1 check("R9");

    // R4: clear between edges at a nonzero count
    tick(0, 1, 1, 1, 1, "");
    #1 rst_n = 1'b0;
    #1 check("R4");
    @(negedge clk); rst_n = 1'b1;

    // random mix
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      rst_n    = ($urandom % 64) != 0;
      cnt_en   = ($urandom % 4) != 0;
      load_n   = ($urandom % 10) != 0;
      blank_n  = ($urandom % 6) != 0;
      lamp_n   = ($urandom % 6) != 0;
      zblank_n = ($urandom % 3) != 0;
      #1 check("");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule